// File: doc/BRIEF.md
# Page Patch Sequencer

This block is an SPI master that rewrites a run of bytes inside one page of a serial page-organised flash that has a single on-chip SRAM page buffer. The rest of the page is left unchanged. A host hands over one request holding a page number, a starting byte offset inside the page and a byte count. The new bytes then arrive on a separate stream.

For each request the block runs three SPI commands in a fixed order:
1. A page-to-buffer load.
2. A buffer write that carries the new bytes at the requested offset.
3. A buffer-to-page program.

After the load and again after the program it releases chip select and polls the device status until the ready bit is set. The serial clock is derived from the system clock by a divider and always runs in SPI mode 0. A request whose bytes would run past the end of the page is refused at once and produces no serial traffic.

Both host-side inputs use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the block is idle. A data byte is taken on an edge where `wr_valid` and `wr_ready` are both high, and `wr_ready` rises only when the write command is ready for its next byte. If the host holds `wr_valid` low, the block waits with chip select low and the serial clock parked low. Status and control pins are plain levels or pulses.

Top module: `pgupd_host`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, `spi_cs_n` is 1, `spi_sck` is 0, `busy`, `done` and `err` are 0, and `req_ready` is 1.
- R2: A request with a count of 0, or with offset plus count greater than 264, is refused. `err` is high for exactly the one clock after the accepting edge, `busy` stays 0, and `spi_cs_n` stays 1.
- R3: An accepted request produces frames in this order: load (opcode 53h), status polls, buffer write (opcode 84h), program (opcode `PROG_OP`, default 83h), status polls. Each frame is bounded by a fall and a rise of `spi_cs_n`.
- R4: Load, write and program frames start with the 8-bit opcode, sent MSB first. Next come 24 address bits, MSB first: 6 zero bits, the 9-bit page number, then a 9-bit byte offset. The offset field is the request offset for the write frame and 0 for the load and program frames.
- R5: A status poll frame is opcode `STAT_OP` (default D7h) followed by one byte read from `spi_miso`. Polling repeats while the first bit read (bit 7) is 0 and moves on once it is 1.
- R6: The write frame carries exactly `req_count` bytes taken from the stream in arrival order. `wr_ready` is high only inside the write frame while it awaits a byte.
- R7: SPI mode 0 is used: `spi_cs_n` changes only while `spi_sck` is low, `spi_mosi` is stable while `spi_sck` is high, and every high or low phase of `spi_sck` inside a frame lasts at least `HALF_DIV` clocks.
- R8: `busy` is high from the clock after acceptance up to, but not including, the clock in which `done` pulses. `done` is a single-clock pulse that coincides with the rise of `spi_cs_n` ending the final successful poll. `req_ready` equals the inverse of `busy`.
- R9: After `done`, the target page holds its previous content with only bytes offset to offset+count-1 replaced by the streamed data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_page | input | 9 | Target page number |
| req_offset | input | 9 | First byte to replace within the page |
| req_count | input | 9 | Number of bytes to replace |
| wr_valid | input | 1 | Data byte offered |
| wr_ready | output | 1 | Data byte can be taken |
| wr_data | input | 8 | Data byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | One-clock refusal pulse |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Device select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The status outputs have fixed delays:
- `busy` and `err` are due on the first clock after the accepting edge.
- `done` is due in the same clock as the chip-select rise that ends the last ready poll, and `busy` falls in that same clock.

The bench latches each acceptance at the rising edge where it happens. It compares `busy`, `done`, `err` and `req_ready` against its model at every falling edge, so each expected value lands exactly one edge after its cause. Frame content, the number of polls and the final page image come from a behavioural device model driven by the serial pins. That model answers "not ready" a known number of times, so the expected command log is fixed in advance.

// File: rtl/pgupd_pkg.sv
package pgupd_pkg;
  localparam int PAGE_W     = 9;
  localparam int OFS_W      = 9;
  localparam int CNT_W      = 9;
  localparam int PAGE_BYTES = 264;
  localparam int ADDR_BITS  = 24;
  localparam logic [7:0] LOAD_OP = 8'h53;
  localparam logic [7:0] FILL_OP = 8'h84;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_WAIT1,
    ST_FILL,
    ST_COMMIT,
    ST_WAIT2
  } step_e;
endpackage

// File: rtl/pgupd_spi_byte.sv
// Mode-0 byte shifter: SCK idles low, MOSI changes while SCK is low,
// MISO is sampled as SCK rises. Only the first received bit is kept.
module pgupd_spi_byte #(
  parameter int HALF_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       done,
  output logic       rx_msb,
  output logic       sck,
  output logic       mosi
);
  localparam int DW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic          active;
  logic [DW-1:0] div;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  assign mosi = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      div    <= '0;
      bitn   <= '0;
      sh     <= '0;
      sck    <= 1'b0;
      done   <= 1'b0;
      rx_msb <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          sh     <= tx;
          div    <= '0;
          bitn   <= '0;
        end
      end else if (div == DIV_LAST) begin
        div <= '0;
        if (!sck) begin
          sck <= 1'b1;
          if (bitn == 3'd0) rx_msb <= miso;
        end else begin
          sck <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            sh   <= {sh[6:0], 1'b0};
          end
        end
      end else begin
        div <= div + DW'(1);
      end
    end
  end

  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi)) else $error("mosi moved while sck high"); // R7
endmodule

// File: rtl/pgupd_seq.sv
module pgupd_seq
  import pgupd_pkg::*;
#(
  parameter int         GAP_CYC = 8,
  parameter logic [7:0] PROG_OP = 8'h83,
  parameter logic [7:0] STAT_OP = 8'hD7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              eng_start,
  output logic [7:0]        eng_tx,
  input  logic              eng_done,
  input  logic              eng_rx_msb,
  output logic              cs_n,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int GW    = $clog2(GAP_CYC + 1);
  localparam int PAD_W = ADDR_BITS - PAGE_W - OFS_W;
  localparam int SUM_W = ((OFS_W > CNT_W) ? OFS_W : CNT_W) + 1;

  step_e             step;
  logic [GW-1:0]     gap;
  logic [2:0]        idx;
  logic              inflight;
  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [CNT_W-1:0]  left_q;

  logic              poll, can_issue, need_data, hdr_issue, frame_end, bad_req;
  logic [2:0]        fixed_len;
  logic [7:0]        opcode, hdr_byte;
  logic [ADDR_BITS-1:0] addr24;
  logic [SUM_W-1:0]  req_end;

  assign poll      = (step == ST_WAIT1) || (step == ST_WAIT2);
  assign fixed_len = poll ? 3'd2 : 3'd4;
  assign addr24    = {{PAD_W{1'b0}}, page_q, (step == ST_FILL) ? ofs_q : {OFS_W{1'b0}}};
  assign can_issue = !cs_n && !inflight;
  assign need_data = (step == ST_FILL) && (idx == 3'd4) && (left_q != '0);
  assign hdr_issue = can_issue && (idx < fixed_len);
  assign frame_end = can_issue && (idx == fixed_len) && !need_data;
  assign wr_ready  = can_issue && need_data;
  assign eng_start = hdr_issue || (wr_ready && wr_valid);
  assign req_end   = SUM_W'(req_offset) + SUM_W'(req_count);
  assign bad_req   = (req_count == '0) || (req_end > SUM_W'(PAGE_BYTES));
  assign busy      = (step != ST_IDLE);
  assign req_ready = (step == ST_IDLE);

  always_comb begin
    case (step)
      ST_LOAD:   opcode = LOAD_OP;
      ST_FILL:   opcode = FILL_OP;
      ST_COMMIT: opcode = PROG_OP;
      default:   opcode = STAT_OP;
    endcase
    case (idx)
      3'd0:    hdr_byte = opcode;
      3'd1:    hdr_byte = poll ? 8'h00 : addr24[23:16];
      3'd2:    hdr_byte = addr24[15:8];
      default: hdr_byte = addr24[7:0];
    endcase
    eng_tx = need_data ? wr_data : hdr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step     <= ST_IDLE;
      cs_n     <= 1'b1;
      gap      <= '0;
      idx      <= '0;
      inflight <= 1'b0;
      page_q   <= '0;
      ofs_q    <= '0;
      left_q   <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (eng_done) inflight <= 1'b0;
      if (eng_start) begin
        inflight <= 1'b1;
        if (idx < 3'd4) idx <= idx + 3'd1;
        if (need_data) left_q <= left_q - CNT_W'(1);
      end
      if (step == ST_IDLE) begin
        if (req_valid) begin
          if (bad_req) begin
            err <= 1'b1;
          end else begin
            step   <= ST_LOAD;
            page_q <= req_page;
            ofs_q  <= req_offset;
            left_q <= req_count;
            gap    <= '0;
          end
        end
      end else if (cs_n) begin
        if (gap == '0) begin
          cs_n <= 1'b0;
          idx  <= '0;
        end else begin
          gap <= gap - GW'(1);
        end
      end else if (frame_end) begin
        cs_n <= 1'b1;
        gap  <= GW'(GAP_CYC - 1);
        case (step)
          ST_LOAD:   step <= ST_WAIT1;
          ST_WAIT1:  if (eng_rx_msb) step <= ST_FILL;
          ST_FILL:   step <= ST_COMMIT;
          ST_COMMIT: step <= ST_WAIT2;
          default: if (eng_rx_msb) begin
            step <= ST_IDLE;
            done <= 1'b1;
          end
        endcase
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one clock"); // R8
  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready) else $error("request taken while busy"); // R8
  AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cs_n && !busy)) else $error("refused request started traffic"); // R2
  AST_DATA_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (!cs_n && busy)) else $error("data byte outside write frame"); // R6
endmodule

// File: rtl/pgupd_host.sv
module pgupd_host
  import pgupd_pkg::*;
#(
  parameter int         HALF_DIV = 8,
  parameter int         GAP_CYC  = 8,
  parameter logic [7:0] PROG_OP  = 8'h83,
  parameter logic [7:0] STAT_OP  = 8'hD7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic       eng_start, eng_done, eng_rx_msb;
  logic [7:0] eng_tx;

  pgupd_seq #(
    .GAP_CYC(GAP_CYC), .PROG_OP(PROG_OP), .STAT_OP(STAT_OP)
  ) seq_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .req_offset(req_offset), .req_count(req_count),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .eng_start(eng_start), .eng_tx(eng_tx), .eng_done(eng_done), .eng_rx_msb(eng_rx_msb),
    .cs_n(spi_cs_n), .busy(busy), .done(done), .err(err)
  );

  pgupd_spi_byte #(.HALF_DIV(HALF_DIV)) eng_i (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .tx(eng_tx), .miso(spi_miso),
    .done(eng_done), .rx_msb(eng_rx_msb), .sck(spi_sck), .mosi(spi_mosi)
  );

  AST_CS_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(spi_cs_n) || $fell(spi_cs_n)) |-> !spi_sck) else $error("cs edge with sck high"); // R7
  AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck) else $error("sck high while deselected"); // R7
  AST_DONE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_cs_n && !busy)) else $error("done while frame open"); // R8
endmodule

// File: tb/pgupd_host_tb_top.sv
module pgupd_host_tb_top;
  localparam int HALF = 8;
  localparam int GAP  = 8;
  localparam int PB   = 264;
  localparam logic [7:0] PROG = 8'h83;
  localparam logic [7:0] STAT = 8'hD7;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, wr_valid, wr_ready, busy, done, err;
  logic [8:0] req_page, req_offset, req_count;
  logic [7:0] wr_data;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso;

  always #2.5 clk = ~clk;

  pgupd_host #(.HALF_DIV(HALF), .GAP_CYC(GAP), .PROG_OP(PROG), .STAT_OP(STAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .req_offset(req_offset), .req_count(req_count),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .busy(busy), .done(done), .err(err),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int tests = 0;
  int fails = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural device model ----------------
  logic [7:0] mem [int];
  logic [7:0] bufm [PB];
  logic [7:0] fr [$];
  logic [7:0] oplog [$];
  logic [7:0] sh = '0;
  int  bitcnt = 0;
  int  busy_polls = 0;
  bit  stat_rdy = 1'b0;
  bit  is_stat = 1'b0;
  bit  post_prog = 1'b0;
  bit  final_flag = 1'b0;
  int  exp_page = 0, exp_ofs = 0, exp_cnt = 0;
  logic [7:0] stat_byte;

  function automatic logic [7:0] rdm(input int p, input int i);
    int k = p * PB + i;
    if (mem.exists(k)) return mem[k];
    return 8'(k * 13 + 5);
  endfunction

  assign stat_byte = stat_rdy ? 8'h88 : 8'h08;
  assign spi_miso  = (is_stat && bitcnt >= 8 && bitcnt < 16) ? stat_byte[3'(15 - bitcnt)] : 1'b0;

  always @(negedge spi_cs_n) begin
    bitcnt = 0;
    fr.delete();
    is_stat = 1'b0;
    stat_rdy = (busy_polls == 0);
  end

  always @(posedge spi_sck) if (spi_cs_n === 1'b0) begin
    sh = {sh[6:0], spi_mosi};
    bitcnt++;
    if (bitcnt % 8 == 0) begin
      fr.push_back(sh);
      if (bitcnt == 8 && sh == STAT) is_stat = 1'b1;
    end
  end

  always @(posedge spi_cs_n) if (fr.size() > 0) begin
    logic [7:0] op;
    logic [23:0] a24;
    op = fr[0];
    oplog.push_back(op);
    if (op == STAT) begin
      check(fr.size() == 2, "R5 poll frame length", fr.size(), 2);
      if (busy_polls > 0) busy_polls--;
      if (stat_rdy && post_prog) begin
        final_flag = 1'b1;
        post_prog = 1'b0;
      end
    end else if (fr.size() >= 4) begin
      a24 = {fr[1], fr[2], fr[3]};
      check(a24[23:18] == 6'd0, "R4 pad bits", int'(a24[23:18]), 0);
      check(int'(a24[17:9]) == exp_page, "R4 page field", int'(a24[17:9]), exp_page);
      check(int'(a24[8:0]) == ((op == 8'h84) ? exp_ofs : 0), "R4 offset field",
            int'(a24[8:0]), (op == 8'h84) ? exp_ofs : 0);
      if (op == 8'h53) begin
        check(fr.size() == 4, "R3 load frame length", fr.size(), 4);
        for (int i = 0; i < PB; i++) bufm[i] = rdm(int'(a24[17:9]), i);
        busy_polls = 2;
      end else if (op == 8'h84) begin
        check(fr.size() - 4 == exp_cnt, "R6 data byte count", fr.size() - 4, exp_cnt);
        for (int k = 4; k < fr.size(); k++)
          if (int'(a24[8:0]) + k - 4 < PB) bufm[int'(a24[8:0]) + k - 4] = fr[k];
      end else if (op == PROG) begin
        check(fr.size() == 4, "R3 program frame length", fr.size(), 4);
        for (int i = 0; i < PB; i++) mem[int'(a24[17:9]) * PB + i] = bufm[i];
        busy_polls = 3;
        post_prog = 1'b1;
      end else begin
        check(1'b0, "R3 unknown opcode", int'(op), 0);
      end
    end else begin
      check(1'b0, "R4 short frame", fr.size(), 4);
    end
  end

  // ---------------- cycle-level reference model ----------------
  bit run_chk = 1'b0;
  bit in_flight = 1'b0;
  bit err_exp = 1'b0;
  bit acc_good = 1'b0;
  bit acc_bad = 1'b0;
  logic last_sck = 1'b0, last_cs = 1'b1, last_mosi = 1'b0;
  int run = 1000;

  always @(posedge clk) if (rst_n === 1'b1 && req_valid && req_ready) begin
    if (req_count != 0 && int'(req_offset) + int'(req_count) <= PB) acc_good = 1'b1;
    else acc_bad = 1'b1;
  end

  always @(negedge clk) if (run_chk) begin
    if (acc_good) in_flight = 1'b1;
    if (acc_bad) err_exp = 1'b1;
    acc_good = 1'b0;
    acc_bad = 1'b0;
    check(busy === (in_flight && !final_flag), "R8 busy", busy, in_flight && !final_flag);
    check(done === final_flag, "R8 done", done, final_flag);
    check(req_ready === !busy, "R8 req_ready", req_ready, !busy);
    check(err === err_exp, "R2 err pulse", err, err_exp);
    if (!in_flight) check(spi_cs_n === 1'b1, "R2 no traffic while idle", spi_cs_n, 1);
    if (spi_cs_n !== last_cs) check(spi_sck === 1'b0, "R7 cs edge with sck low", spi_sck, 0);
    if (spi_sck && last_sck && spi_mosi !== last_mosi)
      check(1'b0, "R7 mosi stable while sck high", spi_mosi, last_mosi);
    if (spi_cs_n === 1'b0) begin
      if (spi_sck !== last_sck) begin
        check(run >= HALF, "R7 sck phase length", run, HALF);
        run = 1;
      end else run++;
    end else run = 1000;
    last_sck = spi_sck;
    last_cs = spi_cs_n;
    last_mosi = spi_mosi;
    if (final_flag) begin
      in_flight = 1'b0;
      final_flag = 1'b0;
    end
    err_exp = 1'b0;
  end

  // ---------------- stimulus ----------------
  task automatic do_req(input int page, input int ofs, input int cnt, input bit stall);
    logic [7:0] d [$];
    logic [7:0] expg [PB];
    logic [7:0] expops [$];
    int k = 0;
    int cyc = 0;
    int mism = 0;
    exp_page = page; exp_ofs = ofs; exp_cnt = cnt;
    for (int i = 0; i < cnt; i++) d.push_back(8'(page + ofs * 3 + i * 29 + 1));
    for (int i = 0; i < PB; i++) expg[i] = rdm(page, i);
    for (int i = 0; i < cnt; i++) expg[ofs + i] = d[i];
    oplog.delete();
    @(negedge clk);
    req_valid = 1'b1; req_page = 9'(page); req_offset = 9'(ofs); req_count = 9'(cnt);
    @(negedge clk);
    req_valid = 1'b0;
    while (k < cnt && cyc < 40000) begin
      @(negedge clk);
      cyc++;
      if (stall && (cyc % 3 == 0)) wr_valid = 1'b0;
      else begin
        wr_valid = 1'b1;
        wr_data = d[k];
      end
      if (wr_valid && wr_ready) k++;
    end
    @(negedge clk);
    wr_valid = 1'b0;
    while (in_flight && cyc < 40000) begin
      @(negedge clk);
      cyc++;
    end
    check(!in_flight, "R8 request completes", in_flight, 0);
    expops = '{8'h53, STAT, STAT, STAT, 8'h84, PROG, STAT, STAT, STAT, STAT};
    check(oplog.size() == expops.size(), "R3 frame count", oplog.size(), expops.size());
    for (int i = 0; i < expops.size() && i < oplog.size(); i++)
      check(oplog[i] == expops[i], (i == 0 || i == 4 || i == 5) ? "R3 opcode order" : "R5 poll sequence",
            int'(oplog[i]), int'(expops[i]));
    for (int i = 0; i < PB; i++) if (rdm(page, i) !== expg[i]) mism++;
    check(mism == 0, "R9 page content", mism, 0);
  endtask

  task automatic do_bad(input int ofs, input int cnt);
    oplog.delete();
    @(negedge clk);
    req_valid = 1'b1; req_page = 9'd7; req_offset = 9'(ofs); req_count = 9'(cnt);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (40) @(negedge clk);
    check(oplog.size() == 0, "R2 refused request sends nothing", oplog.size(), 0);
    check(busy === 1'b0, "R2 busy stays low", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_page = '0; req_offset = '0; req_count = '0;
    wr_valid = 1'b0; wr_data = '0;
    repeat (4) @(negedge clk);
    check(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1 serial pins in reset", {spi_cs_n, spi_sck}, 2);
    check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1 status in reset", {busy, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1 && spi_cs_n === 1'b1, "R1 idle after reset", {req_ready, spi_cs_n}, 3);
    run_chk = 1'b1;
    do_req(5, 10, 4, 1'b0);
    do_req(511, 260, 4, 1'b1);
    do_req(0, 0, 1, 1'b0);
    do_bad(200, 65);
    do_bad(3, 0);
    do_req(5, 8, 5, 1'b1);
    do_req(300, 0, 16, 1'b1);
    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule